// File: doc/BRIEF.md
# Multi-Level Tagged Translation Cache

This block is a fully associative cache of finished address translations for an I/O memory management unit. Each entry holds the result of one table walk: the output base address, the address mask that says how large the mapped region is, and two permission bits. The entry is tagged by its address-space ID, its level-aligned input address, its granule code and the table level at which the walk ended. The same input address can therefore be covered by a large block at a low level or by a small page at level 3.

A lookup names an address-space ID, an input address, a granule code and the table size field. The controller works out the first table level that can exist for that configuration. It then probes one level per cycle, lowest first, and compares every entry in parallel at each probe. The first level that hits ends the search. A walker fills the cache through the insert port. Software-driven maintenance reaches it through a single invalidation port with four operation codes. Two counters record every lookup outcome.

Top module: `iotlb_cache`

## Requirements
- R1: An entry hits a probe only if it is valid and its ID, granule code and level equal the probe's, and its stored base equals the lookup address ANDed with the inverse of the level mask. The granule log2 g is 12 for code 0, else 2*code+10. The level mask is (1 << s) - 1 with s = g + (3 - level)*(g - 3), all ones when s reaches the address width.
- R2: The first probed level is 4 - q, where q = (64 - tsz - 4) / (g - 3). It is 0 when q >= 4 and 4 when 64 - tsz <= 4. Levels are probed in ascending order up to 3, so an entry at level L is found only if L is at or above that first level. A first level of 4 gives an immediate miss.
- R3: A response is a one-cycle rspValid pulse. On a hit it carries the stored output base, mask and permission bits of the hitting entry, the lowest-indexed one when several match. On a miss these fields are zero.
- R4: Every response increments exactly one of hitCnt and missCnt, according to rspHit. Both counters are zero after reset.
- R5: An insert stores its address ANDed with the inverse of the mask of its own level and granule code. It fills the lowest-indexed free slot.
- R6: An insert arriving while every slot is valid first invalidates all entries, then stores the new one in slot 0.
- R7: Invalidation op 0 removes every entry.
- R8: Invalidation op 1 removes every entry whose ID equals invAsid.
- R9: Op 2 with a nonzero level hint invTtl and invPages == 1 removes only entries whose base equals invAddr, whose granule code equals invTg and whose level equals invTtl.
- R10: Any other op 2 uses the range mask (invPages << g) - 1, with g derived from invTg as in R1. It removes an entry when invAddr masked by the entry's mask equals the entry base, or when the entry base masked by the range mask equals invAddr.
- R11: In op 2, invAnyAsid set makes the ID match every entry; otherwise the IDs must be equal. Op 3 changes nothing.
- R12: While invValid is high, lkReady is low and a running probe holds its level for that cycle without responding, so a lookup never sees an entry removed in that cycle.
- R13: An insert in the same cycle as an invalidation is applied after the invalidation. Slots freed by it count as free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request |
| lkReady | output | 1 | Lookup can be accepted this cycle |
| lkAsid | input | ASID_W | Lookup address-space ID |
| lkAddr | input | ADDR_W | Lookup input address |
| lkTg | input | 2 | Lookup granule code |
| lkTsz | input | 6 | Lookup table size field |
| rspValid | output | 1 | Response pulse |
| rspHit | output | 1 | Response hit flag |
| rspOut | output | OUT_W | Output base address |
| rspMask | output | ADDR_W | Region address mask |
| rspPerm | output | 2 | Permission bits (bit0 read, bit1 write) |
| insValid | input | 1 | Insert strobe |
| insAsid | input | ASID_W | Insert ID |
| insAddr | input | ADDR_W | Insert input address |
| insTg | input | 2 | Insert granule code |
| insLevel | input | 2 | Insert table level |
| insOut | input | OUT_W | Insert output base |
| insPerm | input | 2 | Insert permission bits |
| invValid | input | 1 | Invalidation strobe |
| invOp | input | 2 | 0 all, 1 by ID, 2 range, 3 none |
| invAsid | input | ASID_W | Invalidation ID |
| invAnyAsid | input | 1 | Range ID wildcard |
| invAddr | input | ADDR_W | Range address |
| invTg | input | 2 | Range granule code |
| invPages | input | PAGES_W | Range page count |
| invTtl | input | 2 | Range level hint, 0 for none |
| hitCnt | output | CNT_W | Lookup hit count |
| missCnt | output | CNT_W | Lookup miss count |

## Verification
A lookup and an invalidation can fall in the same cycle in two ways. A request can arrive together with the invalidation, or the invalidation can land while a multi-level probe is under way. The bench provokes both on purpose. It holds a request high across an invalidation cycle, and it removes the very entry a running probe is about to reach. It also pairs an insert with an ID invalidation in one cycle. In each case the response is judged against a model that applies the invalidation first, so a stale hit or a lost request shows up as a miscompare.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

  typedef enum logic [1:0] {
    INV_ALL   = 2'd0,
    INV_ID    = 2'd1,
    INV_RANGE = 2'd2,
    INV_NOP   = 2'd3
  } inv_op_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic       probe;
    logic [1:0] level;
  } probe_strb_t;

  function automatic logic [5:0] granLog2(input logic [1:0] tg);
    return (tg == 2'd0) ? 6'd12 : (6'({tg, 1'b0}) + 6'd10);
  endfunction

  function automatic logic [63:0] levelMask(input logic [1:0] lvl, input logic [1:0] tg);
    logic [5:0] g;
    logic [6:0] sh;
    g  = granLog2(tg);
    sh = 7'(g) + 7'(2'd3 - lvl) * 7'(g - 6'd3);
    return (64'd1 << sh) - 64'd1;
  endfunction

  function automatic logic [2:0] startLevel(input logic [5:0] tsz, input logic [1:0] tg);
    logic [6:0] inSize;
    logic [6:0] q;
    inSize = 7'd64 - 7'(tsz);
    if (inSize <= 7'd4) return 3'd4;
    q = (inSize - 7'd4) / 7'(granLog2(tg) - 6'd3);
    if (q >= 7'd4) return 3'd0;
    return 3'd4 - 3'(q);
  endfunction

endpackage

// File: rtl/iotlb_store.sv
module iotlb_store
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 48,
  parameter int OUT_W   = 48,
  parameter int ASID_W  = 16,
  parameter int PAGES_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  probe_strb_t        strb,
  input  logic [ASID_W-1:0]  keyAsid,
  input  logic [ADDR_W-1:0]  keyAddr,
  input  logic [1:0]         keyTg,
  output logic               matchHit,
  output logic [OUT_W-1:0]   matchOut,
  output logic [ADDR_W-1:0]  matchMask,
  output logic [1:0]         matchPerm,
  input  logic               insValid,
  input  logic [ASID_W-1:0]  insAsid,
  input  logic [ADDR_W-1:0]  insAddr,
  input  logic [1:0]         insTg,
  input  logic [1:0]         insLevel,
  input  logic [OUT_W-1:0]   insOut,
  input  logic [1:0]         insPerm,
  input  logic               invValid,
  input  logic [1:0]         invOp,
  input  logic [ASID_W-1:0]  invAsid,
  input  logic               invAnyAsid,
  input  logic [ADDR_W-1:0]  invAddr,
  input  logic [1:0]         invTg,
  input  logic [PAGES_W-1:0] invPages,
  input  logic [1:0]         invTtl
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [ASID_W-1:0]  eAsid [ENTRIES];
  logic [ADDR_W-1:0]  eBase [ENTRIES];
  logic [ADDR_W-1:0]  eMask [ENTRIES];
  logic [OUT_W-1:0]   eOut  [ENTRIES];
  logic [1:0]         eTg   [ENTRIES];
  logic [1:0]         eLvl  [ENTRIES];
  logic [1:0]         ePerm [ENTRIES];

  logic [63:0]        probeMask64, rangeMask64, insMask64;
  logic [ADDR_W-1:0]  probeBase, rangeMask, insMask;
  logic               fastPath;
  inv_op_e            op;
  logic [ENTRIES-1:0] lkVec, invVec, killVec, vldAfter;
  logic               full;
  logic [IDX_W-1:0]   freeIdx, slot;

  always_comb begin
    probeMask64 = levelMask(strb.level, keyTg);
    probeBase   = keyAddr & ~probeMask64[ADDR_W-1:0];
    rangeMask64 = (64'(invPages) << granLog2(invTg)) - 64'd1;
    rangeMask   = rangeMask64[ADDR_W-1:0];
    fastPath    = (invTtl != 2'd0) && (invPages == PAGES_W'(1));
    op          = inv_op_e'(invOp);
    insMask64   = levelMask(insLevel, insTg);
    insMask     = insMask64[ADDR_W-1:0];
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic idOk, exact, overlap;
    assign lkVec[i] = vld[i] && (eAsid[i] == keyAsid) && (eTg[i] == keyTg) &&
                      (eLvl[i] == strb.level) && (eBase[i] == probeBase);
    always_comb begin
      idOk    = invAnyAsid || (eAsid[i] == invAsid);
      exact   = (eBase[i] == invAddr) && (eTg[i] == invTg) && (eLvl[i] == invTtl);
      overlap = ((invAddr & ~eMask[i]) == eBase[i]) || ((eBase[i] & ~rangeMask) == invAddr);
      case (op)
        INV_ALL:   invVec[i] = 1'b1;
        INV_ID:    invVec[i] = (eAsid[i] == invAsid);
        INV_RANGE: invVec[i] = idOk && (fastPath ? exact : overlap);
        default:   invVec[i] = 1'b0;
      endcase
    end
  end

  // lowest index wins
  always_comb begin
    matchHit  = 1'b0;
    matchOut  = '0;
    matchMask = '0;
    matchPerm = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkVec[i]) begin
        matchHit  = 1'b1;
        matchOut  = eOut[i];
        matchMask = eMask[i];
        matchPerm = ePerm[i];
      end
    end
  end

  always_comb begin
    killVec  = invValid ? (invVec & vld) : '0;
    vldAfter = vld & ~killVec;
    full     = &vldAfter;
    freeIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vldAfter[i]) freeIdx = IDX_W'(i);
    end
    slot = full ? '0 : freeIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
    end else if (insValid) begin
      vld <= full ? ENTRIES'(1) : (vldAfter | (ENTRIES'(1) << freeIdx));
    end else begin
      vld <= vldAfter;
    end
  end

  always_ff @(posedge clk) begin
    if (insValid) begin
      eAsid[slot] <= insAsid;
      eBase[slot] <= insAddr & ~insMask;
      eMask[slot] <= insMask;
      eOut[slot]  <= insOut;
      eTg[slot]   <= insTg;
      eLvl[slot]  <= insLevel;
      ePerm[slot] <= insPerm;
    end
  end

  // R6
  ins_full_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !invValid && (&vld)) |=> (vld[0] && $countones(vld) == 1));

  // R7
  inv_all_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && invOp == 2'd0 && !insValid) |=> (vld == '0));

  // R5
  ins_grows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !invValid && !(&vld)) |=> ($countones(vld) == $past($countones(vld)) + 1));

endmodule

// File: rtl/iotlb_ctrl.sv
module iotlb_ctrl
  import iotlb_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int OUT_W  = 48,
  parameter int ASID_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  output logic              lkReady,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [1:0]        lkTg,
  input  logic [5:0]        lkTsz,
  input  logic              invValid,
  output probe_strb_t       strb,
  output logic [ASID_W-1:0] keyAsid,
  output logic [ADDR_W-1:0] keyAddr,
  output logic [1:0]        keyTg,
  input  logic              matchHit,
  input  logic [OUT_W-1:0]  matchOut,
  input  logic [ADDR_W-1:0] matchMask,
  input  logic [1:0]        matchPerm,
  output logic              rspValid,
  output logic              rspHit,
  output logic [OUT_W-1:0]  rspOut,
  output logic [ADDR_W-1:0] rspMask,
  output logic [1:0]        rspPerm,
  output logic [CNT_W-1:0]  hitCnt,
  output logic [CNT_W-1:0]  missCnt
);

  typedef enum logic {ST_IDLE, ST_PROBE} state_e;

  state_e     st;
  logic [1:0] curLevel;
  logic [2:0] firstLevel;
  logic       accept;

  always_comb begin
    lkReady     = (st == ST_IDLE) && !invValid;
    accept      = lkValid && lkReady;
    firstLevel  = startLevel(lkTsz, lkTg);
    strb.probe  = (st == ST_PROBE) && !invValid;
    strb.level  = curLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      curLevel <= '0;
      keyAsid  <= '0;
      keyAddr  <= '0;
      keyTg    <= '0;
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspOut   <= '0;
      rspMask  <= '0;
      rspPerm  <= '0;
      hitCnt   <= '0;
      missCnt  <= '0;
    end else begin
      rspValid <= 1'b0;
      if (accept) begin
        keyAsid <= lkAsid;
        keyAddr <= lkAddr;
        keyTg   <= lkTg;
        if (firstLevel[2]) begin
          rspValid <= 1'b1;
          rspHit   <= 1'b0;
          rspOut   <= '0;
          rspMask  <= '0;
          rspPerm  <= '0;
          missCnt  <= missCnt + 1'b1;
        end else begin
          st       <= ST_PROBE;
          curLevel <= firstLevel[1:0];
        end
      end else if (strb.probe) begin
        if (matchHit) begin
          rspValid <= 1'b1;
          rspHit   <= 1'b1;
          rspOut   <= matchOut;
          rspMask  <= matchMask;
          rspPerm  <= matchPerm;
          hitCnt   <= hitCnt + 1'b1;
          st       <= ST_IDLE;
        end else if (curLevel == 2'd3) begin
          rspValid <= 1'b1;
          rspHit   <= 1'b0;
          rspOut   <= '0;
          rspMask  <= '0;
          rspPerm  <= '0;
          missCnt  <= missCnt + 1'b1;
          st       <= ST_IDLE;
        end else begin
          curLevel <= curLevel + 2'd1;
        end
      end
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((CNT_W+1)'(hitCnt) + (CNT_W+1)'(missCnt) ==
                  (CNT_W+1)'($past(hitCnt)) + (CNT_W+1)'($past(missCnt)) + 1));

  // R2
  probe_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PROBE && $past(st == ST_PROBE)) |->
      (curLevel == 2'($past(curLevel) + {1'b0, ~$past(invValid)})));

  // R12
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PROBE && invValid) |=> (st == ST_PROBE && !rspValid));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspOut == '0 && rspMask == '0 && rspPerm == 2'd0));

endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 48,
  parameter int OUT_W   = 48,
  parameter int ASID_W  = 16,
  parameter int PAGES_W = 8,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  output logic               lkReady,
  input  logic [ASID_W-1:0]  lkAsid,
  input  logic [ADDR_W-1:0]  lkAddr,
  input  logic [1:0]         lkTg,
  input  logic [5:0]         lkTsz,
  output logic               rspValid,
  output logic               rspHit,
  output logic [OUT_W-1:0]   rspOut,
  output logic [ADDR_W-1:0]  rspMask,
  output logic [1:0]         rspPerm,
  input  logic               insValid,
  input  logic [ASID_W-1:0]  insAsid,
  input  logic [ADDR_W-1:0]  insAddr,
  input  logic [1:0]         insTg,
  input  logic [1:0]         insLevel,
  input  logic [OUT_W-1:0]   insOut,
  input  logic [1:0]         insPerm,
  input  logic               invValid,
  input  logic [1:0]         invOp,
  input  logic [ASID_W-1:0]  invAsid,
  input  logic               invAnyAsid,
  input  logic [ADDR_W-1:0]  invAddr,
  input  logic [1:0]         invTg,
  input  logic [PAGES_W-1:0] invPages,
  input  logic [1:0]         invTtl,
  output logic [CNT_W-1:0]   hitCnt,
  output logic [CNT_W-1:0]   missCnt
);

  probe_strb_t        strb;
  logic [ASID_W-1:0]  keyAsid;
  logic [ADDR_W-1:0]  keyAddr;
  logic [1:0]         keyTg;
  logic               matchHit;
  logic [OUT_W-1:0]   matchOut;
  logic [ADDR_W-1:0]  matchMask;
  logic [1:0]         matchPerm;

  iotlb_ctrl #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .ASID_W(ASID_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkReady(lkReady), .lkAsid(lkAsid),
    .lkAddr(lkAddr), .lkTg(lkTg), .lkTsz(lkTsz), .invValid(invValid), .strb(strb),
    .keyAsid(keyAsid), .keyAddr(keyAddr), .keyTg(keyTg), .matchHit(matchHit),
    .matchOut(matchOut), .matchMask(matchMask), .matchPerm(matchPerm),
    .rspValid(rspValid), .rspHit(rspHit), .rspOut(rspOut), .rspMask(rspMask),
    .rspPerm(rspPerm), .hitCnt(hitCnt), .missCnt(missCnt)
  );

  iotlb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .OUT_W(OUT_W), .ASID_W(ASID_W),
                .PAGES_W(PAGES_W)) store_i (
    .clk(clk), .rstN(rstN), .strb(strb), .keyAsid(keyAsid), .keyAddr(keyAddr),
    .keyTg(keyTg), .matchHit(matchHit), .matchOut(matchOut), .matchMask(matchMask),
    .matchPerm(matchPerm), .insValid(insValid), .insAsid(insAsid), .insAddr(insAddr),
    .insTg(insTg), .insLevel(insLevel), .insOut(insOut), .insPerm(insPerm),
    .invValid(invValid), .invOp(invOp), .invAsid(invAsid), .invAnyAsid(invAnyAsid),
    .invAddr(invAddr), .invTg(invTg), .invPages(invPages), .invTtl(invTtl)
  );

endmodule

// File: tb/iotlb_cache_tb_top.sv
module iotlb_cache_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lkValid, lkReady, rspValid, rspHit;
  logic [15:0] lkAsid;
  logic [47:0] lkAddr, rspOut, rspMask;
  logic [1:0]  lkTg, rspPerm;
  logic [5:0]  lkTsz;
  logic        insValid;
  logic [15:0] insAsid;
  logic [47:0] insAddr, insOut;
  logic [1:0]  insTg, insLevel, insPerm;
  logic        invValid, invAnyAsid;
  logic [1:0]  invOp, invTg, invTtl;
  logic [15:0] invAsid;
  logic [47:0] invAddr;
  logic [7:0]  invPages;
  logic [31:0] hitCnt, missCnt;

  int vectors = 0, errors = 0, expHits = 0, expMiss = 0;

  always #4 clk = ~clk;

  iotlb_cache dut_i (.*);

  // reference model
  logic        mV    [N];
  logic [15:0] mAsid [N];
  logic [47:0] mBase [N], mMask [N], mOut [N];
  logic [1:0]  mTg   [N], mLvl [N], mPerm [N];

  function automatic int gLog(input int tg);
    return (tg == 0) ? 12 : tg * 2 + 10;
  endfunction

  function automatic logic [47:0] lvlMask(input int l, input int tg);
    int g, sh;
    g  = gLog(tg);
    sh = g + (3 - l) * (g - 3);
    if (sh >= 48) return '1;
    return (48'd1 << sh) - 48'd1;
  endfunction

  function automatic int firstLvl(input int tsz, input int tg);
    int is, q;
    is = 64 - tsz;
    if (is <= 4) return 4;
    q = (is - 4) / (gLog(tg) - 3);
    if (q >= 4) return 0;
    return 4 - q;
  endfunction

  task automatic mLookup(input logic [15:0] a, input logic [47:0] ad, input int tg, input int tsz,
                         output logic h, output logic [47:0] o, output logic [47:0] m,
                         output logic [1:0] p);
    h = 0; o = '0; m = '0; p = '0;
    for (int l = firstLvl(tsz, tg); l <= 3 && !h; l++) begin
      for (int i = 0; i < N && !h; i++) begin
        if (mV[i] && mAsid[i] == a && mTg[i] == 2'(tg) && mLvl[i] == 2'(l) &&
            mBase[i] == (ad & ~lvlMask(l, tg))) begin
          h = 1; o = mOut[i]; m = mMask[i]; p = mPerm[i];
        end
      end
    end
  endtask

  task automatic mIns(input logic [15:0] a, input logic [47:0] ad, input int tg, input int l,
                      input logic [47:0] o, input logic [1:0] p);
    int slot = -1;
    for (int i = N - 1; i >= 0; i--) if (!mV[i]) slot = i;
    if (slot < 0) begin
      for (int i = 0; i < N; i++) mV[i] = 0;
      slot = 0;
    end
    mV[slot] = 1; mAsid[slot] = a; mMask[slot] = lvlMask(l, tg);
    mBase[slot] = ad & ~lvlMask(l, tg); mOut[slot] = o; mTg[slot] = 2'(tg);
    mLvl[slot] = 2'(l); mPerm[slot] = p;
  endtask

  task automatic mInv(input int op, input logic [15:0] a, input logic any, input logic [47:0] ad,
                      input int tg, input int pages, input int ttl);
    logic [47:0] rm;
    logic aok, kill;
    rm = (48'(pages) << gLog(tg)) - 48'd1;
    for (int i = 0; i < N; i++) begin
      aok = any || (mAsid[i] == a);
      case (op)
        0: kill = 1;
        1: kill = (mAsid[i] == a);
        2: if (ttl != 0 && pages == 1)
             kill = aok && mBase[i] == ad && mTg[i] == 2'(tg) && mLvl[i] == 2'(ttl);
           else
             kill = aok && (((ad & ~mMask[i]) == mBase[i]) || ((mBase[i] & ~rm) == ad));
        default: kill = 0;
      endcase
      if (kill) mV[i] = 0;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic driveIns(input logic [15:0] a, input logic [47:0] ad, input int tg, input int l,
                          input logic [47:0] o, input logic [1:0] p);
    insAsid = a; insAddr = ad; insTg = 2'(tg); insLevel = 2'(l); insOut = o; insPerm = p;
    insValid = 1;
  endtask

  task automatic driveInv(input int op, input logic [15:0] a, input logic any, input logic [47:0] ad,
                          input int tg, input int pages, input int ttl);
    invOp = 2'(op); invAsid = a; invAnyAsid = any; invAddr = ad; invTg = 2'(tg);
    invPages = 8'(pages); invTtl = 2'(ttl); invValid = 1;
  endtask

  task automatic insert(input logic [15:0] a, input logic [47:0] ad, input int tg, input int l,
                        input logic [47:0] o, input logic [1:0] p);
    @(negedge clk); driveIns(a, ad, tg, l, o, p);
    @(posedge clk); mIns(a, ad, tg, l, o, p);
    @(negedge clk); insValid = 0;
  endtask

  task automatic inval(input int op, input logic [15:0] a, input logic any, input logic [47:0] ad,
                       input int tg, input int pages, input int ttl);
    @(negedge clk); driveInv(op, a, any, ad, tg, pages, ttl);
    @(posedge clk); mInv(op, a, any, ad, tg, pages, ttl);
    @(negedge clk); invValid = 0;
  endtask

  task automatic waitCmp(input string req, input logic eh, input logic [47:0] eo,
                         input logic [47:0] em, input logic [1:0] ep);
    int k = 0;
    while (!rspValid && k < 12) begin @(negedge clk); k++; end
    chk(rspValid, {req, " rspValid"}, 64'(rspValid), 64'd1);
    chk(rspHit == eh, {req, " hit"}, 64'(rspHit), 64'(eh));
    chk(rspOut == eo && rspMask == em && rspPerm == ep, {req, " R3 fields"},
        {rspOut[31:0], rspMask[31:0]}, {eo[31:0], em[31:0]});
    if (eh) expHits++; else expMiss++;
  endtask

  task automatic lookup(input logic [15:0] a, input logic [47:0] ad, input int tg, input int tsz,
                        input string req);
    logic eh; logic [47:0] eo, em; logic [1:0] ep;
    mLookup(a, ad, tg, tsz, eh, eo, em, ep);
    @(negedge clk); lkAsid = a; lkAddr = ad; lkTg = 2'(tg); lkTsz = 6'(tsz); lkValid = 1;
    @(negedge clk); lkValid = 0;
    waitCmp(req, eh, eo, em, ep);
  endtask

  function automatic logic [47:0] rAddr();
    return (48'($urandom % 4) << 21) | (48'($urandom % 4) << 12) | 48'($urandom % 64);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic eh; logic [47:0] eo, em; logic [1:0] ep;
    void'($urandom(32'h1c0ffee));
    for (int i = 0; i < N; i++) mV[i] = 0;
    rstN = 0; lkValid = 0; insValid = 0; invValid = 0;
    lkAsid = 0; lkAddr = 0; lkTg = 1; lkTsz = 16;
    insAsid = 0; insAddr = 0; insTg = 1; insLevel = 3; insOut = 0; insPerm = 0;
    invOp = 3; invAsid = 0; invAnyAsid = 0; invAddr = 0; invTg = 0; invPages = 1; invTtl = 0;
    repeat (3) @(negedge clk);
    chk(rspValid == 0, "R3 reset rspValid", 64'(rspValid), 0);
    chk(hitCnt == 0 && missCnt == 0, "R4 reset counters", 64'(hitCnt + missCnt), 0);
    rstN = 1;
    @(negedge clk);
    chk(lkReady == 1, "R12 idle ready", 64'(lkReady), 1);

    // R1 R2: level-2 block, start level 1 from tsz 25
    insert(16'd1, 48'h12_3456_7890, 1, 2, 48'hAA_0000_0000, 2'b11);
    lookup(16'd1, 48'h12_3450_0001, 1, 25, "R1 block hit");
    lookup(16'd2, 48'h12_3450_0001, 1, 25, "R1 id mismatch");
    lookup(16'd1, 48'h12_3450_0001, 2, 25, "R1 tg mismatch");
    lookup(16'd1, 48'h12_3450_0001, 1, 43, "R2 start above level");
    lookup(16'd1, 48'h12_3450_0001, 1, 55, "R2 immediate miss");
    // R5: page at level 3 in a slot after the block, masked base
    insert(16'd1, 48'h12_3456_7FFF, 1, 3, 48'hBB_0000_0000, 2'b01);
    lookup(16'd1, 48'h12_3456_7123, 1, 43, "R5 page hit");
    lookup(16'd1, 48'h12_3456_7123, 1, 16, "R2 lower level first");
    // R11 op 3 no effect
    inval(3, 16'd1, 1, 48'h0, 0, 1, 0);
    lookup(16'd1, 48'h12_3456_7123, 1, 43, "R11 nop");
    // R9 fast path exact page
    inval(2, 16'd1, 0, 48'h12_3456_7000, 1, 1, 3);
    lookup(16'd1, 48'h12_3456_7123, 1, 43, "R9 fast page gone");
    lookup(16'd1, 48'h12_3456_7123, 1, 25, "R9 block kept");
    // R10 range over block via entry base, wildcard R11
    inval(2, 16'd9, 1, 48'h12_3440_0000, 0, 4, 0);
    lookup(16'd1, 48'h12_3456_7123, 1, 25, "R10 R11 range kill");
    // R8 by id
    insert(16'd3, 48'h1000, 1, 3, 48'h3000, 2'b10);
    insert(16'd4, 48'h1000, 1, 3, 48'h4000, 2'b10);
    inval(1, 16'd3, 0, 48'h0, 0, 1, 0);
    lookup(16'd3, 48'h1000, 1, 43, "R8 removed");
    lookup(16'd4, 48'h1000, 1, 43, "R8 kept");
    // R6 overflow
    inval(0, 16'd0, 0, 48'h0, 0, 1, 0);
    lookup(16'd4, 48'h1000, 1, 43, "R7 all");
    for (int i = 0; i <= N; i++) insert(16'd5, 48'(i) << 12, 1, 3, 48'(i + 1), 2'b01);
    lookup(16'd5, 48'h0, 1, 43, "R6 old gone");
    lookup(16'd5, 48'(N) << 12, 1, 43, "R6 new in slot");
    for (int i = 1; i < N; i++) insert(16'd5, 48'(i + 32) << 12, 1, 3, 48'(i), 2'b01);
    // R13 insert with invalidation in one cycle
    @(negedge clk); driveInv(1, 16'd5, 0, 48'h0, 0, 1, 0);
    driveIns(16'd6, 48'h77000, 1, 3, 48'h6600, 2'b11);
    @(posedge clk); mInv(1, 16'd5, 0, 48'h0, 0, 1, 0); mIns(16'd6, 48'h77000, 1, 3, 48'h6600, 2'b11);
    @(negedge clk); invValid = 0; insValid = 0;
    lookup(16'd6, 48'h77abc, 1, 43, "R13 insert after inv");
    lookup(16'd5, 48'h21000, 1, 43, "R13 inv applied");

    // R12 request during invalidation
    insert(16'd7, 48'h9000, 1, 3, 48'h7700, 2'b01);
    @(negedge clk);
    lkAsid = 7; lkAddr = 48'h9000; lkTg = 1; lkTsz = 16; lkValid = 1;
    driveInv(2, 16'd7, 0, 48'h9000, 1, 1, 3);
    #1 chk(lkReady == 0, "R12 blocked", 64'(lkReady), 0);
    @(posedge clk); mInv(2, 16'd7, 0, 48'h9000, 1, 1, 3);
    @(negedge clk); invValid = 0;
    chk(rspValid == 0, "R12 no early rsp", 64'(rspValid), 0);
    mLookup(16'd7, 48'h9000, 1, 16, eh, eo, em, ep);
    @(negedge clk); lkValid = 0;
    waitCmp("R12 post inv", eh, eo, em, ep);
    // R12 invalidation during running probe
    insert(16'd7, 48'h9000, 1, 3, 48'h7700, 2'b01);
    @(negedge clk); lkAsid = 7; lkAddr = 48'h9000; lkTg = 1; lkTsz = 16; lkValid = 1;
    @(negedge clk); lkValid = 0; driveInv(2, 16'd7, 0, 48'h9000, 1, 1, 3);
    @(posedge clk); mInv(2, 16'd7, 0, 48'h9000, 1, 1, 3);
    @(negedge clk); invValid = 0;
    chk(rspValid == 0, "R12 probe held", 64'(rspValid), 0);
    mLookup(16'd7, 48'h9000, 1, 16, eh, eo, em, ep);
    waitCmp("R12 mid probe", eh, eo, em, ep);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 20;
      int tg = ($urandom % 4 == 0) ? 1 + $urandom % 3 : 1;
      logic [15:0] a = 16'(1 + $urandom % 3);
      if (r < 8)       insert(a, rAddr(), tg, $urandom % 4, 48'($urandom), 2'($urandom));
      else if (r < 16) lookup(a, rAddr(), tg, 16 + 9 * ($urandom % 4), "R1 R2 random");
      else if (r < 17) inval(1, a, 0, 48'h0, 0, 1, 0);
      else if (r < 19) inval(2, a, $urandom % 2, rAddr() & ~48'hFFF, $urandom % 4,
                             1 + $urandom % 4, $urandom % 4);
      else if ($urandom % 4 == 0) inval(0, a, 0, 48'h0, 0, 1, 0);
    end

    @(negedge clk);
    chk(hitCnt == 32'(expHits), "R4 hits", 64'(hitCnt), 64'(expHits));
    chk(missCnt == 32'(expMiss), "R4 misses", 64'(missCnt), 64'(expMiss));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule